// File: doc/BRIEF.md
# Fractional Clock Divider

This block derives a slower clock waveform and a matching one-cycle clock-enable from a reference clock. It is clocked by `clk_i`, which runs at twice the reference frequency. Each `clk_i` cycle is one half-period of the reference, called a tick below. Reference rising edges fall on the load edge after reset and on every second `clk_i` edge after it. Counting ticks instead of reference cycles lets half-integer ratios such as 1.5 or 7.5 come from an odd tick count, so the logic needs no negative-edge flops.

A 5-bit select picks one of 22 ratios. Codes 0 to 13 give 1.5 to 8 in steps of 0.5. Codes 14 to 21 give the integers 9 to 16. An optional halving stage doubles the effective ratio. A duty-fix input picks either a near-50% waveform or a short fixed high pulse. The select, halve and duty-fix inputs are captured only on the first clock edge after reset is released. A change in any of them therefore needs a reset, and a running waveform never produces a shortened pulse. `ready_o` rises once the first full output period has completed.

Top module: `fdiv_top`

## Requirements
- R1: While `rst_ni` is low, `div_o`, `ce_o` and `ready_o` are all low.
- R2: For select codes 0 to 13, the output period is code+3 ticks, which gives ratios 1.5 to 8.
- R3: For select codes 14 to 21, the output period is 2*(code-5) ticks, which gives integer ratios 9 to 16.
- R4: Select codes 22 to 31 behave exactly as code 1, a ratio of 2 with a period of 4 ticks.
- R5: With `halve_i` high, the period is twice the R2/R3/R4 value.
- R6: With `duty_fix_i` high, `div_o` is high for ceil(period/2) ticks of each period. With it low, `div_o` is high for 2 ticks, or 4 ticks when halving. For an odd integer ratio this ends the high phase on a reference falling edge.
- R7: `div_o` is high in the first cycle after the load edge and rises at tick 0 of every period. For even periods, every rise therefore lands on a reference rising edge.
- R8: `ce_o` is high for exactly one cycle per period, and that cycle is the one in which `div_o` rises.
- R9: `ready_o` stays low through the first period, goes high at the start of the second period, and then stays high until reset.
- R10: Changes on `sel_i`, `halve_i` or `duty_fix_i` after the load edge have no effect on the outputs until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, twice the reference frequency |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 5 | Ratio select code |
| halve_i | input | 1 | Halve the reference before dividing |
| duty_fix_i | input | 1 | Select the near-50% high time |
| div_o | output | 1 | Divided clock waveform |
| ce_o | output | 1 | One-cycle enable at each rise of `div_o` |
| ready_o | output | 1 | First full period has completed |

## Verification
The bench targets the smallest odd period (code 0), where a design that wraps its counter one tick late would stretch every pulse. It also targets the largest period with halving, where a counter that is too narrow would wrap early. It checks the boundary between the half-step and integer code ranges (13 to 14) and an unused code. An off-by-one decode at either point would show up as a wrong period. It also changes the select in mid-run: a design that re-reads its inputs live would shift its period at once. Finally, it watches `ready_o` at the first wrap, which catches a flag raised one period early or on the load edge.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int SEL_W        = 5;
  localparam int FINE_CODES   = 14;  // half-step ratios
  localparam int ALL_CODES    = 22;
  localparam int MIN_HALF     = 3;   // ticks for the smallest ratio
  localparam int COARSE_HALF0 = 18;  // ticks for the first integer-only code
  localparam int DEF_HALF     = 4;   // fallback for unused codes
  localparam int MAX_HALF     = COARSE_HALF0 + 2 * (ALL_CODES - FINE_CODES - 1);
  localparam int PER_W        = $clog2(2 * MAX_HALF + 2);

  typedef struct packed {
    logic [PER_W-1:0] period;
    logic [PER_W-1:0] high;
  } cfg_t;
endpackage

// File: rtl/fdiv_decode.sv
module fdiv_decode
  import fdiv_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  logic             halve_i,
  input  logic             duty_fix_i,
  output cfg_t             cfg_o
);
  logic [PER_W-1:0] half_ticks;
  logic [PER_W-1:0] period;

  always_comb begin
    if (int'(sel_i) < FINE_CODES)
      half_ticks = PER_W'(int'(sel_i) + MIN_HALF);
    else if (int'(sel_i) < ALL_CODES)
      half_ticks = PER_W'(COARSE_HALF0 + 2 * (int'(sel_i) - FINE_CODES));
    else
      half_ticks = PER_W'(DEF_HALF);
  end

  assign period = halve_i ? (half_ticks << 1) : half_ticks;

  always_comb begin
    cfg_o.period = period;
    if (duty_fix_i) cfg_o.high = (period + PER_W'(1)) >> 1;
    else            cfg_o.high = halve_i ? PER_W'(4) : PER_W'(2);
  end
endmodule

// File: rtl/fdiv_count.sv
module fdiv_count #(
  parameter int PER_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PER_W-1:0] period_i,
  output logic [PER_W-1:0] cnt_o,
  output logic [PER_W-1:0] cnt_nxt_o
);
  logic wrap;

  assign wrap      = (cnt_o == period_i - PER_W'(1));
  assign cnt_nxt_o = !run_i ? '0 : (wrap ? '0 : cnt_o + PER_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_nxt_o;
  end
endmodule

// File: rtl/fdiv_wave.sv
module fdiv_wave #(
  parameter int PER_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PER_W-1:0] high_i,
  input  logic [PER_W-1:0] cnt_nxt_i,
  output logic             div_o,
  output logic             ce_o,
  output logic             ready_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o   <= 1'b0;
      ce_o    <= 1'b0;
      ready_o <= 1'b0;
    end else if (!run_i) begin
      // load edge opens the first period
      div_o <= 1'b1;
      ce_o  <= 1'b1;
    end else begin
      div_o   <= (cnt_nxt_i < high_i);
      ce_o    <= (cnt_nxt_i == '0);
      ready_o <= ready_o | (cnt_nxt_i == '0);
    end
  end
endmodule

// File: rtl/fdiv_top.sv
module fdiv_top
  import fdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             halve_i,
  input  logic             duty_fix_i,
  output logic             div_o,
  output logic             ce_o,
  output logic             ready_o
);
  cfg_t             cfg_d, cfg_q;
  logic             run_q;
  logic [PER_W-1:0] cnt_q, cnt_nxt;
  logic [PER_W-1:0] per_q;

  fdiv_decode i_decode (
    .sel_i      (sel_i),
    .halve_i    (halve_i),
    .duty_fix_i (duty_fix_i),
    .cfg_o      (cfg_d)
  );

  // configuration is captured once, on the load edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cfg_q <= '0;
    end else if (!run_q) begin
      run_q <= 1'b1;
      cfg_q <= cfg_d;
    end
  end

  assign per_q = cfg_q.period;

  fdiv_count #(.PER_W(PER_W)) i_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .period_i  (cfg_q.period),
    .cnt_o     (cnt_q),
    .cnt_nxt_o (cnt_nxt)
  );

  fdiv_wave #(.PER_W(PER_W)) i_wave (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .high_i    (cfg_q.high),
    .cnt_nxt_i (cnt_nxt),
    .div_o     (div_o),
    .ce_o      (ce_o),
    .ready_o   (ready_o)
  );
endmodule

// File: rtl/fdiv_chk.sv
module fdiv_chk #(
  parameter int PER_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             div_o,
  input logic             ce_o,
  input logic             ready_o,
  input logic             run_i,
  input logic [PER_W-1:0] cnt_i,
  input logic [PER_W-1:0] per_i
);
  // R8
  ce_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_o |-> $rose(div_o));
  // R8
  rise_has_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_o) |-> ce_o);
  // R9
  ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  // R10
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> $stable(per_i));
  // R2
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_i < per_i));
endmodule

bind fdiv_top fdiv_chk #(.PER_W(fdiv_pkg::PER_W)) i_fdiv_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .div_o   (div_o),
  .ce_o    (ce_o),
  .ready_o (ready_o),
  .run_i   (run_q),
  .cnt_i   (cnt_q),
  .per_i   (per_q)
);

// File: tb/test_fdiv_top.sv
module test_fdiv_top;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] sel_i = '0;
  logic       halve_i = 1'b0;
  logic       duty_fix_i = 1'b0;
  logic       div_o, ce_o, ready_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit    div;
    bit    ce;
    bit    rdy;
    string tag;
  } item_t;

  item_t sb_q[$];

  always #(CLK_P/2) clk_i = ~clk_i;

  fdiv_top i_fdiv_top (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_i),
    .halve_i    (halve_i),
    .duty_fix_i (duty_fix_i),
    .div_o      (div_o),
    .ce_o       (ce_o),
    .ready_o    (ready_o)
  );

  function automatic int exp_period(int sel, bit h);
    int hp;
    if (sel < 14)      hp = sel + 3;
    else if (sel < 22) hp = 2 * (sel - 5);
    else               hp = 4;
    return h ? 2 * hp : hp;
  endfunction

  function automatic int exp_high(int p, bit h, bit fix);
    if (fix) return (p + 1) / 2;
    return h ? 4 : 2;
  endfunction

  task automatic check(bit act, bit exp, string req, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // monitor: compare one expected item per cycle, away from the active edge
  always @(negedge clk_i) begin
    if (sb_q.size() != 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(div_o, it.div, it.tag, "div_o");
      check(ce_o, it.ce, "R8", "ce_o");
      check(ready_o, it.rdy, "R9", "ready_o");
    end
  end

  // driver: reset, load configuration, push expected waveform
  task automatic run_case(int sel, bit h, bit fix, string tag, bit poke);
    int p, hi, n;
    @(negedge clk_i);
    rst_ni     = 1'b0;
    sel_i      = 5'(sel);
    halve_i    = h;
    duty_fix_i = fix;
    @(negedge clk_i);
    check(div_o, 1'b0, "R1", "div_o in reset");
    check(ce_o, 1'b0, "R1", "ce_o in reset");
    check(ready_o, 1'b0, "R1", "ready_o in reset");
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    p  = exp_period(sel, h);
    hi = exp_high(p, h, fix);
    n  = 3 * p + 2;
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.div = ((k % p) < hi);
      it.ce  = ((k % p) == 0);
      it.rdy = (k >= p);
      it.tag = (k == 0) ? "R7" : tag;
      sb_q.push_back(it);
    end
    if (poke) begin
      repeat (2) @(negedge clk_i);
      sel_i      = 5'd21;
      halve_i    = ~h;
      duty_fix_i = ~fix;
    end
    wait (sb_q.size() == 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    run_case(0,  1'b0, 1'b1, "R2", 1'b0);  // ratio 1.5, odd period
    run_case(0,  1'b0, 1'b0, "R6", 1'b0);
    run_case(1,  1'b0, 1'b1, "R2", 1'b0);
    run_case(3,  1'b0, 1'b1, "R6", 1'b0);  // ratio 3, high ends on falling edge
    run_case(13, 1'b0, 1'b1, "R2", 1'b0);  // ratio 8
    run_case(14, 1'b0, 1'b1, "R3", 1'b0);  // ratio 9
    run_case(21, 1'b0, 1'b0, "R3", 1'b0);  // ratio 16
    run_case(27, 1'b0, 1'b1, "R4", 1'b0);  // unused code
    run_case(31, 1'b1, 1'b0, "R4", 1'b0);
    run_case(0,  1'b1, 1'b1, "R5", 1'b0);
    run_case(21, 1'b1, 1'b1, "R5", 1'b0);  // largest period
    run_case(6,  1'b1, 1'b0, "R6", 1'b0);
    run_case(4,  1'b0, 1'b1, "R10", 1'b1); // inputs change mid-run
    run_case(2,  1'b1, 1'b0, "R10", 1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule